// File: doc/BRIEF.md
# Interval Down-Counter Timer

This block is a register-mapped timer that counts down from a programmed interval and flags a timeout when its count reaches zero. Software talks to it over a plain slave port (word address, write strobe, write data, combinational read data). It can start and halt the count, pick between a single-shot interval and automatic reload, enable an interrupt, and poll a timeout flag and a running flag.

The interval lives in a period register that is split into two 16-bit halves. A build-time parameter decides whether software may change the period. When it cannot, writing either half leaves the value untouched and only rewinds the count to the fixed build-time interval. The default interval is also a parameter. Its full-scale all-ones default suits a free-running timestamp source.

Top module: `intv_timer`

## Requirements
- R1: After reset, TO, RUN, the interrupt enable and the reload mode are all 0, the irq output is low, and the period reads back DEFAULT_PERIOD.
- R2: Register map by word address: 0 is status (bit 0 TO, bit 1 RUN), 1 is control (bit 0 interrupt enable, bit 1 continuous reload, bit 2 START, bit 3 STOP), 2 is period bits 15:0, 3 is period bits 31:16. Unused bits read 0, and START and STOP always read 0.
- R3: A write with START=1 sets RUN on that clock edge. With period P loaded, the count then decrements once per clock, and TO is set on the (P+1)th clock edge after the START edge.
- R4: In single-shot mode (reload bit 0), the timeout edge clears RUN and reloads the count from the period, so a later START times a full interval again.
- R5: In continuous mode (reload bit 1), the timeout edge reloads the period while RUN stays 1, so TO is set again every P+1 clocks.
- R6: A write with STOP=1 clears RUN and freezes the count with no timeout. A later START resumes from the frozen count.
- R7: If START and STOP are both 1 in one control write, STOP wins and RUN ends at 0.
- R8: Any write to status clears TO, whatever the data (0x0000 and 0xFFFF alike). A timeout on the same edge takes precedence over the clear.
- R9: irq is high exactly when the interrupt enable and TO are both 1. Setting the enable while TO is already 1 raises irq on that write edge.
- R10: With a writeable period, writing one half replaces only that half in the readback, stops the counter, and loads the count with the new period.
- R11: With a fixed period, writing either half leaves the readback at DEFAULT_PERIOD, stops the counter, and reloads the count with DEFAULT_PERIOD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W (2) | Word address of the register accessed |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_wdata | input | DATA_W (16) | Write data |
| bus_rdata | output | DATA_W (16) | Read data for bus_addr, combinational |
| irq | output | 1 | Interrupt, high while enabled and timed out |

## Verification
Every register update happens on the clock edge that samples the write strobe. Status, control, period readback and irq therefore change one edge after a write, and the bench reads them at the following falling edge. The timeout is due P+1 edges after the START edge, and in continuous mode P+1 edges after the previous timeout. The bench checks the flag one cycle before that edge, where it must still be clear, and again just after it, where it must be set. It counts only falling edges from the falling edge at which the write task returns. A resumed count is predicted from the number of edges that elapsed before the STOP edge.

// File: rtl/intv_timer_pkg.sv
// Package intv_timer_pkg
// Shared register offsets, bit positions and the decoded command type for
// the interval timer. Assumes a word-addressed register file.
package intv_timer_pkg;

    // Word offsets of the registers
    localparam int unsigned OFS_STATUS = 0;
    localparam int unsigned OFS_CTRL   = 1;
    localparam int unsigned OFS_PERIOD = 2;

    // Status bit positions
    localparam int unsigned ST_TO  = 0;
    localparam int unsigned ST_RUN = 1;

    // Control bit positions
    localparam int unsigned CT_ITO   = 0;
    localparam int unsigned CT_CONT  = 1;
    localparam int unsigned CT_START = 2;
    localparam int unsigned CT_STOP  = 3;

    // One-cycle command bundle produced by the bus decoder
    typedef struct packed {
        logic status_wr;
        logic ctrl_wr;
        logic start_p;
        logic stop_p;
        logic ito_d;
        logic cont_d;
    } ctl_cmd_t;

endpackage

// File: rtl/intv_timer_decode.sv
// Module intv_timer_decode
// Turns a bus write into one-cycle strobes: status clear, control update,
// START/STOP pulses and one write enable per period half.
// Assumes one register access per cycle; STOP priority is applied downstream.
module intv_timer_decode
    import intv_timer_pkg::*;
#(
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned NUM_HALVES = 2,
    parameter int unsigned ADDR_W     = 2
) (
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output ctl_cmd_t              cmd,
    output logic [NUM_HALVES-1:0] per_we
);

    logic unused_hi;

    // Bits above STOP carry no control meaning
    assign unused_hi = ^bus_wdata[DATA_W-1:CT_STOP+1];

    // Decode the status and control accesses into strobes
    always_comb begin : p_ctl_decode
        cmd.status_wr = bus_wr && (bus_addr == ADDR_W'(OFS_STATUS));
        cmd.ctrl_wr   = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
        cmd.start_p   = cmd.ctrl_wr && bus_wdata[CT_START];
        cmd.stop_p    = cmd.ctrl_wr && bus_wdata[CT_STOP];
        cmd.ito_d     = bus_wdata[CT_ITO];
        cmd.cont_d    = bus_wdata[CT_CONT];
    end

    // One write enable per period half, laid out from OFS_PERIOD upward
    for (genvar gi = 0; gi < NUM_HALVES; gi++) begin : g_half_we
        assign per_we[gi] = bus_wr && (bus_addr == ADDR_W'(OFS_PERIOD + gi));
    end

endmodule

// File: rtl/intv_timer_period.sv
// Module intv_timer_period
// Holds the timeout period. When WRITABLE is set, each half can be replaced
// by a bus write. When it is clear, the period is the constant DEFAULT.
// Either way a write to any half raises per_load, and per_next is the value
// that the counter must take on that edge.
module intv_timer_period #(
    parameter int unsigned          DATA_W     = 16,
    parameter int unsigned          NUM_HALVES = 2,
    parameter int unsigned          PERIOD_W   = 32,
    parameter bit                   WRITABLE   = 1'b1,
    parameter logic [PERIOD_W-1:0]  DEFAULT    = '1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_HALVES-1:0] per_we,
    input  logic [DATA_W-1:0]     wdata,
    output logic [PERIOD_W-1:0]   period_q,
    output logic [PERIOD_W-1:0]   per_next,
    output logic                  per_load
);

    // Any half write restarts the counter
    assign per_load = |per_we;

    if (WRITABLE) begin : g_rw
        logic [PERIOD_W-1:0] period_r;

        // Merge the written half into the held period
        for (genvar gi = 0; gi < NUM_HALVES; gi++) begin : g_merge
            assign per_next[gi*DATA_W +: DATA_W] =
                per_we[gi] ? wdata : period_r[gi*DATA_W +: DATA_W];
        end

        // Register the period, starting from the build-time default
        always_ff @(posedge clk) begin : p_period_reg
            if (!rst_n) begin
                period_r <= DEFAULT;
            end else if (per_load) begin
                period_r <= per_next;
            end
        end

        assign period_q = period_r;
    end else begin : g_ro
        logic unused_ro;

        // Fixed period: writes only rewind the counter
        assign unused_ro = ^{wdata, clk, rst_n};
        assign period_q  = DEFAULT;
        assign per_next  = DEFAULT;
    end

endmodule

// File: rtl/intv_timer_counter.sv
// Module intv_timer_counter
// Down-counter with run and timeout state. Precedence on an edge:
// period load, then STOP, then counting, then START. A timeout is the
// running cycle spent at zero. On it the count reloads from the period, and
// the reload mode decides whether RUN stays set. A timeout on the same edge
// as a status write leaves TO set.
module intv_timer_counter #(
    parameter int unsigned         PERIOD_W = 32,
    parameter logic [PERIOD_W-1:0] DEFAULT  = '1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_p,
    input  logic                stop_p,
    input  logic                status_wr,
    input  logic                cont,
    input  logic                per_load,
    input  logic [PERIOD_W-1:0] per_next,
    input  logic [PERIOD_W-1:0] period_q,
    output logic [PERIOD_W-1:0] cnt_q,
    output logic                run_q,
    output logic                to_q
);

    logic at_zero;
    logic tmo;

    // Zero detect and timeout event for this cycle
    assign at_zero = (cnt_q == '0);
    assign tmo     = run_q && at_zero && !per_load && !stop_p;

    // Count and run state with load/stop/count/start precedence
    always_ff @(posedge clk) begin : p_count
        if (!rst_n) begin
            cnt_q <= DEFAULT;
            run_q <= 1'b0;
        end else if (per_load) begin
            cnt_q <= per_next;
            run_q <= 1'b0;
        end else if (stop_p) begin
            run_q <= 1'b0;
        end else if (run_q) begin
            if (at_zero) begin
                cnt_q <= period_q;
                run_q <= cont;
            end else begin
                cnt_q <= cnt_q - PERIOD_W'(1);
            end
        end else if (start_p) begin
            run_q <= 1'b1;
        end
    end

    // Timeout flag: set by a timeout, cleared by any status write
    always_ff @(posedge clk) begin : p_to_flag
        if (!rst_n) begin
            to_q <= 1'b0;
        end else if (tmo) begin
            to_q <= 1'b1;
        end else if (status_wr) begin
            to_q <= 1'b0;
        end
    end

endmodule

// File: rtl/intv_timer.sv
// Module intv_timer (top)
// Register-mapped interval down-counter with an interrupt output. Assumes a
// synchronous slave port with one access per cycle and no wait states. Read
// data is combinational from the register state.
module intv_timer
    import intv_timer_pkg::*;
#(
    parameter int unsigned          DATA_W          = 16,
    parameter int unsigned          PERIOD_W        = 32,
    parameter bit                   WRITABLE_PERIOD = 1'b1,
    parameter logic [PERIOD_W-1:0]  DEFAULT_PERIOD  = '1,
    localparam int unsigned         NUM_HALVES      = PERIOD_W / DATA_W,
    localparam int unsigned         ADDR_W          = $clog2(OFS_PERIOD + NUM_HALVES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    ctl_cmd_t                cmd;
    logic [NUM_HALVES-1:0]   per_we;
    logic [PERIOD_W-1:0]     period_q;
    logic [PERIOD_W-1:0]     per_next;
    logic                    per_load;
    logic [PERIOD_W-1:0]     cnt_q;
    logic                    run_q;
    logic                    to_q;
    logic                    ito_q;
    logic                    cont_q;

    intv_timer_decode #(
        .DATA_W     (DATA_W),
        .NUM_HALVES (NUM_HALVES),
        .ADDR_W     (ADDR_W)
    ) u_decode (
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cmd       (cmd),
        .per_we    (per_we)
    );

    intv_timer_period #(
        .DATA_W     (DATA_W),
        .NUM_HALVES (NUM_HALVES),
        .PERIOD_W   (PERIOD_W),
        .WRITABLE   (WRITABLE_PERIOD),
        .DEFAULT    (DEFAULT_PERIOD)
    ) u_period (
        .clk      (clk),
        .rst_n    (rst_n),
        .per_we   (per_we),
        .wdata    (bus_wdata),
        .period_q (period_q),
        .per_next (per_next),
        .per_load (per_load)
    );

    intv_timer_counter #(
        .PERIOD_W (PERIOD_W),
        .DEFAULT  (DEFAULT_PERIOD)
    ) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_p   (cmd.start_p),
        .stop_p    (cmd.stop_p),
        .status_wr (cmd.status_wr),
        .cont      (cont_q),
        .per_load  (per_load),
        .per_next  (per_next),
        .period_q  (period_q),
        .cnt_q     (cnt_q),
        .run_q     (run_q),
        .to_q      (to_q)
    );

    // Control bits that persist: interrupt enable and reload mode
    always_ff @(posedge clk) begin : p_ctrl_reg
        if (!rst_n) begin
            ito_q  <= 1'b0;
            cont_q <= 1'b0;
        end else if (cmd.ctrl_wr) begin
            ito_q  <= cmd.ito_d;
            cont_q <= cmd.cont_d;
        end
    end

    // Select read data; START/STOP and unused bits return zero
    always_comb begin : p_read_mux
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFS_STATUS)) begin
            bus_rdata[ST_TO]  = to_q;
            bus_rdata[ST_RUN] = run_q;
        end else if (bus_addr == ADDR_W'(OFS_CTRL)) begin
            bus_rdata[CT_ITO]  = ito_q;
            bus_rdata[CT_CONT] = cont_q;
        end else begin
            for (int i = 0; i < NUM_HALVES; i++) begin
                if (bus_addr == ADDR_W'(OFS_PERIOD + i)) begin
                    bus_rdata = period_q[i*DATA_W +: DATA_W];
                end
            end
        end
    end

    // Interrupt request while enabled and timed out
    assign irq = ito_q & to_q;

endmodule

// File: rtl/intv_timer_chk.sv
// Module intv_timer_chk
// Assertion checker bound into intv_timer. It observes the slave port and
// the run, timeout, reload-mode, count and period state.
module intv_timer_chk
    import intv_timer_pkg::*;
#(
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned ADDR_W   = 2,
    parameter int unsigned PERIOD_W = 32,
    parameter bit          WRITABLE = 1'b1
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_wr,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [DATA_W-1:0]   bus_wdata,
    input logic                irq,
    input logic                run_q,
    input logic                to_q,
    input logic                cont_q,
    input logic [PERIOD_W-1:0] cnt_q,
    input logic [PERIOD_W-1:0] period_q
);

    logic st_wr, ct_wr, pr_wr, zero_run;
    logic unused_chk;

    assign st_wr    = bus_wr && (bus_addr == ADDR_W'(OFS_STATUS));
    assign ct_wr    = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
    assign pr_wr    = bus_wr && (bus_addr >= ADDR_W'(OFS_PERIOD));
    assign zero_run = run_q && (cnt_q == '0);
    assign unused_chk = ^bus_wdata;

    p_start_runs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ct_wr && bus_wdata[CT_START] && !bus_wdata[CT_STOP]) |=> run_q);

    p_count_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && (cnt_q != '0) && !bus_wr) |=> (cnt_q == $past(cnt_q) - PERIOD_W'(1)));

    p_oneshot_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_run && !cont_q && !bus_wr) |=> (!run_q && to_q && cnt_q == period_q));

    p_cont_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_run && cont_q && !bus_wr) |=> (run_q && to_q && cnt_q == period_q));

    p_frozen_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !bus_wr) |=> $stable(cnt_q));

    p_stop_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ct_wr && bus_wdata[CT_STOP]) |=> !run_q);

    p_to_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && !zero_run) |=> !to_q);

    p_irq_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && !zero_run) |=> !irq);

    p_period_reload_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pr_wr |=> (!run_q && cnt_q == period_q));

    p_fixed_period_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pr_wr && !WRITABLE) |=> $stable(period_q));

endmodule

bind intv_timer intv_timer_chk #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .PERIOD_W (PERIOD_W),
    .WRITABLE (WRITABLE_PERIOD)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .run_q     (run_q),
    .to_q      (to_q),
    .cont_q    (cont_q),
    .cnt_q     (cnt_q),
    .period_q  (period_q)
);

// File: tb/intv_timer_tb.sv
// Directed bench for intv_timer. Two instances share the address and data
// lines: u_dut has a writeable period, u_dut_ro a fixed one. Both default
// to an interval of 10.
module intv_timer_tb;

    localparam logic [1:0] A_ST = 2'd0, A_CT = 2'd1, A_LO = 2'd2, A_HI = 2'd3;
    // status values: bit0 TO, bit1 RUN
    localparam logic [15:0] S_IDLE = 16'h0, S_TO = 16'h1, S_RUN = 16'h2, S_BOTH = 16'h3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic        wr_a = 1'b0, wr_b = 1'b0;
    logic [15:0] rdata_a, rdata_b;
    logic        irq_a, irq_b;
    int          checks = 0;
    int          failures = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    intv_timer #(.WRITABLE_PERIOD(1'b1), .DEFAULT_PERIOD(32'd10)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr_a),
        .bus_wdata(wdata), .bus_rdata(rdata_a), .irq(irq_a));

    intv_timer #(.WRITABLE_PERIOD(1'b0), .DEFAULT_PERIOD(32'd10)) u_dut_ro (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr_b),
        .bus_wdata(wdata), .bus_rdata(rdata_b), .irq(irq_b));

    task automatic check(input string req, input string what,
                         input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
        end
    endtask

    // Write on the next rising edge; called at a falling edge, returns at the next one
    task automatic wr(input bit ro, input logic [1:0] a, input logic [15:0] d);
        addr = a; wdata = d; wr_a = !ro; wr_b = ro;
        @(negedge clk);
        wr_a = 1'b0; wr_b = 1'b0;
    endtask

    task automatic rd(input bit ro, input logic [1:0] a, output logic [15:0] d);
        addr = a;
        #1;
        d = ro ? rdata_b : rdata_a;
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_reg(input bit ro, input logic [1:0] a, input string req,
                             input string what, input logic [15:0] exp);
        logic [15:0] v;
        rd(ro, a, v);
        check(req, what, v, exp);
    endtask

    task automatic t_reset();
        check_reg(0, A_ST, "R1", "status after reset", S_IDLE);
        check_reg(0, A_CT, "R1", "control after reset", 16'h0);
        check_reg(0, A_LO, "R1", "period lo after reset", 16'd10);
        check_reg(0, A_HI, "R1", "period hi after reset", 16'd0);
        check("R1", "irq after reset", {15'd0, irq_a}, 16'd0);
        check_reg(1, A_LO, "R1", "fixed period lo after reset", 16'd10);
    endtask

    task automatic t_period_write();
        wr(0, A_LO, 16'd5);
        check_reg(0, A_LO, "R10", "lo after lo write", 16'd5);
        check_reg(0, A_HI, "R10", "hi after lo write", 16'd0);
        wr(0, A_HI, 16'h0001);
        check_reg(0, A_HI, "R10", "hi after hi write", 16'h0001);
        check_reg(0, A_LO, "R10", "lo kept after hi write", 16'd5);
        wr(0, A_HI, 16'h0000);
        wr(0, A_CT, 16'h0004);
        check_reg(0, A_ST, "R3", "RUN after START", S_RUN);
        wr(0, A_LO, 16'd5);
        check_reg(0, A_ST, "R10", "period write stops counter", S_IDLE);
    endtask

    task automatic t_oneshot();
        wr(0, A_CT, 16'h0004);
        wait_clk(5);
        check_reg(0, A_ST, "R3", "one cycle before timeout", S_RUN);
        wait_clk(1);
        check_reg(0, A_ST, "R4", "one-shot timeout", S_TO);
        wr(0, A_ST, 16'h0000);
        check_reg(0, A_ST, "R8", "clear with data 0", S_IDLE);
        wr(0, A_CT, 16'h0004);
        wait_clk(5);
        check_reg(0, A_ST, "R4", "restart before timeout", S_RUN);
        wait_clk(1);
        check_reg(0, A_ST, "R4", "restart full interval", S_TO);
        wr(0, A_ST, 16'hFFFF);
        check_reg(0, A_ST, "R8", "clear with data FFFF", S_IDLE);
    endtask

    task automatic t_continuous();
        wr(0, A_CT, 16'h0006);
        check_reg(0, A_CT, "R2", "control readback drops START", 16'h0002);
        wait_clk(5);
        check_reg(0, A_ST, "R5", "before first timeout", S_RUN);
        wait_clk(1);
        check_reg(0, A_ST, "R5", "first timeout keeps RUN", S_BOTH);
        wr(0, A_ST, 16'h0001);
        check_reg(0, A_ST, "R8", "clear while running", S_RUN);
        wait_clk(4);
        check_reg(0, A_ST, "R5", "before second timeout", S_RUN);
        wait_clk(1);
        check_reg(0, A_ST, "R5", "second timeout after P+1", S_BOTH);
        wr(0, A_CT, 16'h0008);
        check_reg(0, A_ST, "R6", "STOP clears RUN", S_TO);
        check_reg(0, A_CT, "R2", "control readback drops STOP", 16'h0000);
        wr(0, A_ST, 16'h0000);
    endtask

    task automatic t_stop_resume();
        wr(0, A_LO, 16'd5);
        wr(0, A_CT, 16'h0004);
        wait_clk(2);
        wr(0, A_CT, 16'h0008);
        wait_clk(10);
        check_reg(0, A_ST, "R6", "no timeout while stopped", S_IDLE);
        wr(0, A_CT, 16'h0004);
        wait_clk(3);
        check_reg(0, A_ST, "R6", "resume before remaining count ends", S_RUN);
        wait_clk(1);
        check_reg(0, A_ST, "R6", "resume from frozen count", S_TO);
        wr(0, A_ST, 16'h0000);
    endtask

    task automatic t_start_stop();
        wr(0, A_CT, 16'h000D);
        check_reg(0, A_ST, "R7", "START+STOP leaves stopped", S_IDLE);
        check_reg(0, A_CT, "R7", "control after START+STOP", 16'h0001);
        wr(0, A_CT, 16'h0005);
        check_reg(0, A_ST, "R3", "START with enable runs", S_RUN);
        wr(0, A_CT, 16'h0008);
    endtask

    task automatic t_irq();
        wr(0, A_LO, 16'd5);
        wr(0, A_CT, 16'h0004);
        wait_clk(6);
        check_reg(0, A_ST, "R9", "timeout reached", S_TO);
        check("R9", "irq masked while disabled", {15'd0, irq_a}, 16'd0);
        wr(0, A_CT, 16'h0001);
        check("R9", "irq on enable with TO", {15'd0, irq_a}, 16'd1);
        wr(0, A_ST, 16'h0000);
        check("R9", "irq drops on clear", {15'd0, irq_a}, 16'd0);
        check_reg(0, A_CT, "R9", "enable retained", 16'h0001);
        wr(0, A_CT, 16'h0000);
    endtask

    task automatic t_fixed();
        wr(1, A_LO, 16'd3);
        check_reg(1, A_LO, "R11", "fixed lo ignores write", 16'd10);
        check_reg(1, A_HI, "R11", "fixed hi unchanged", 16'd0);
        wr(1, A_CT, 16'h0004);
        wait_clk(10);
        check_reg(1, A_ST, "R11", "fixed before timeout", S_RUN);
        wait_clk(1);
        check_reg(1, A_ST, "R11", "fixed timeout at default", S_TO);
        wr(1, A_ST, 16'h0000);
        wr(1, A_CT, 16'h0004);
        wait_clk(4);
        wr(1, A_HI, 16'h0007);
        check_reg(1, A_ST, "R11", "fixed period write stops", S_IDLE);
        check_reg(1, A_HI, "R11", "fixed hi ignores write", 16'd0);
        wr(1, A_CT, 16'h0004);
        wait_clk(10);
        check_reg(1, A_ST, "R11", "rewound count before timeout", S_RUN);
        wait_clk(1);
        check_reg(1, A_ST, "R11", "rewound to full default", S_TO);
        check("R9", "fixed instance irq disabled", {15'd0, irq_b}, 16'd0);
    endtask

    initial begin : p_main
        wait_clk(3);
        rst_n = 1'b1;
        t_reset();
        t_period_write();
        t_oneshot();
        t_continuous();
        t_stop_resume();
        t_start_stop();
        t_irq();
        t_fixed();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : p_watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule